// File: doc/BRIEF.md
# On-demand single-word memory-mapped master

This block lets a slow client reach a memory-mapped AXI4 slave one 32-bit word at a time. The client places an address, a write word and a direction bit on its side and then raises a request level. The block turns the rising edge of that level into a single start, runs exactly one single-beat write or read on the AXI channels, and then returns to idle. No test pattern and no compare pass are involved.

The AXI side runs on a fast clock, where a finished beat is visible for only one cycle. The block therefore latches the read word and keeps a completion flag set until the client lowers its request. A client clocked several times slower can then sample both at leisure. A slave response other than OKAY raises an error flag, which stays set until the next transaction starts.

Top module: `axi_word_master`

## Requirements
- R1: While reset is active and in the first cycle after it, every VALID output, BREADY, RREADY, rsp_done and rsp_err are 0.
- R2: A write request stores cmd_wdata at cmd_addr in the slave. A later read request of the same address returns that word on rsp_rdata.
- R3: A request held high starts exactly one transaction. A write produces one AW and one W handshake and no AR handshake. A read produces one AR handshake and no AW handshake.
- R4: rsp_done goes to 1 in the cycle after a W or R beat is accepted. It stays 1 while cmd_req is high, and is 0 in the cycle after cmd_req is sampled low when no beat is accepted.
- R5: Every transaction is a single beat with the following fields:
  - AWLEN and ARLEN are 0.
  - AWSIZE and ARSIZE are 3'b010, meaning 4 bytes.
  - AWBURST and ARBURST are 2'b01 (INCR).
  - WSTRB is 4'hF and WLAST is 1.
- R6: Once asserted, AWVALID, WVALID and ARVALID stay high, with AWADDR, WDATA and ARADDR unchanged, until the matching READY is seen.
- R7: The address and write word are latched when the transaction starts. Changes on cmd_addr or cmd_wdata after the start have no effect on the transaction.
- R8: A BRESP or RRESP other than OKAY (2'b00) at its handshake sets rsp_err. rsp_err returns to 0 when the next transaction starts.
- R9: A rising edge of cmd_req while a transaction is still active starts no further transaction.
- R10: rsp_rdata is loaded on every accepted R beat and holds its value through later write transactions.
- R11: BREADY is high only while a write is active, and RREADY only while a read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | AXI clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_req | input | 1 | Request level from the client |
| cmd_is_write | input | 1 | 1 selects a write, 0 a read |
| cmd_addr | input | ADDR_W | Byte address of the word |
| cmd_wdata | input | DATA_W | Word to write |
| rsp_done | output | 1 | Sticky completion flag |
| rsp_rdata | output | DATA_W | Latched read word |
| rsp_err | output | 1 | Non-OKAY response seen |
| m_awaddr | output | ADDR_W | Write address |
| m_awlen | output | 8 | Write burst length minus one |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_wlast | output | 1 | Last write beat |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_araddr | output | ADDR_W | Read address |
| m_arlen | output | 8 | Read burst length minus one |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_rdata | input | DATA_W | Read data |
| m_rresp | input | 2 | Read response code |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |

## Verification
The hardest case to reach from the ports is a fresh rising edge of the request that arrives while a transaction is still waiting on the slave. The bench model slave has an adjustable number of stall cycles before it raises READY. The bench sets a long stall, then lowers and raises the request in the middle of that wait, and counts address handshakes to show that the second edge was ignored. The same stall window is used to change the client's address and data after the start, which shows that the latched values reach the bus.

// File: rtl/axi_word_pkg.sv
package axi_word_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } wm_state_e;

  localparam logic [1:0] RESP_OKAY  = 2'b00;
  localparam logic [1:0] BURST_INCR = 2'b01;

  // Any response code other than OKAY counts as an error.
  function automatic logic resp_is_error(input logic [1:0] code);
    return code != RESP_OKAY;
  endfunction

  // AXI size field: log2 of the number of bytes in one beat.
  function automatic logic [2:0] size_code(input int unsigned nbytes);
    return 3'($clog2(nbytes));
  endfunction

endpackage

// File: rtl/axi_word_req_edge.sv
module axi_word_req_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic start
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req;
  end

  // One cycle on each low-to-high change of the request level.
  assign start = req & ~req_q;
endmodule

// File: rtl/axi_word_ctrl.sv
module axi_word_ctrl
  import axi_word_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              awready,
  input  logic              wready,
  input  logic              bvalid,
  input  logic              arready,
  input  logic              rvalid,
  output logic              launch,
  output logic              awvalid,
  output logic              wvalid,
  output logic              arvalid,
  output logic              bready,
  output logic              rready,
  output logic [ADDR_W-1:0] awaddr,
  output logic [ADDR_W-1:0] araddr,
  output logic [DATA_W-1:0] wdata_q,
  output logic              wr_beat,
  output logic              rd_beat,
  output logic              b_hs
);
  wm_state_e state;

  assign launch  = start && (state == ST_IDLE);
  assign bready  = (state == ST_WRITE);
  assign rready  = (state == ST_READ);
  assign wr_beat = wvalid && wready;
  assign rd_beat = rvalid && rready;
  assign b_hs    = bvalid && bready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      awvalid <= 1'b0;
      wvalid  <= 1'b0;
      arvalid <= 1'b0;
      awaddr  <= '0;
      araddr  <= '0;
      wdata_q <= '0;
    end else if (launch) begin
      awaddr  <= addr;
      araddr  <= addr;
      wdata_q <= wdata;
      state   <= is_write ? ST_WRITE : ST_READ;
      awvalid <= is_write;
      wvalid  <= is_write;
      arvalid <= !is_write;
    end else begin
      if (awvalid && awready) awvalid <= 1'b0;
      if (wvalid && wready)   wvalid  <= 1'b0;
      if (arvalid && arready) arvalid <= 1'b0;
      if (b_hs || rd_beat)    state   <= ST_IDLE;
    end
  end
endmodule

// File: rtl/axi_word_rsp.sv
module axi_word_rsp
  import axi_word_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              launch,
  input  logic              wr_beat,
  input  logic              rd_beat,
  input  logic              b_hs,
  input  logic [1:0]        bresp,
  input  logic [1:0]        rresp,
  input  logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata_q,
  output logic              err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      rdata_q <= '0;
      err     <= 1'b0;
    end else begin
      if (wr_beat || rd_beat) done <= 1'b1;
      else if (!req)          done <= 1'b0;

      if (rd_beat) rdata_q <= rdata;

      if (launch)                                  err <= 1'b0;
      else if (b_hs && resp_is_error(bresp))       err <= 1'b1;
      else if (rd_beat && resp_is_error(rresp))    err <= 1'b1;
    end
  end
endmodule

// File: rtl/axi_word_master.sv
module axi_word_master
  import axi_word_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_req,
  input  logic                cmd_is_write,
  input  logic [ADDR_W-1:0]   cmd_addr,
  input  logic [DATA_W-1:0]   cmd_wdata,
  output logic                rsp_done,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_err,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [7:0]          m_arlen,
  output logic [2:0]          m_arsize,
  output logic [1:0]          m_arburst,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rvalid,
  output logic                m_rready
);
  localparam int BYTES = DATA_W / 8;

  logic start, launch, wr_beat, rd_beat, b_hs;

  axi_word_req_edge u_edge (
    .clk(clk), .rst_n(rst_n), .req(cmd_req), .start(start)
  );

  axi_word_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .is_write(cmd_is_write),
    .addr(cmd_addr), .wdata(cmd_wdata),
    .awready(m_awready), .wready(m_wready), .bvalid(m_bvalid),
    .arready(m_arready), .rvalid(m_rvalid),
    .launch(launch), .awvalid(m_awvalid), .wvalid(m_wvalid),
    .arvalid(m_arvalid), .bready(m_bready), .rready(m_rready),
    .awaddr(m_awaddr), .araddr(m_araddr), .wdata_q(m_wdata),
    .wr_beat(wr_beat), .rd_beat(rd_beat), .b_hs(b_hs)
  );

  axi_word_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .req(cmd_req), .launch(launch),
    .wr_beat(wr_beat), .rd_beat(rd_beat), .b_hs(b_hs),
    .bresp(m_bresp), .rresp(m_rresp), .rdata(m_rdata),
    .done(rsp_done), .rdata_q(rsp_rdata), .err(rsp_err)
  );

  // Single-beat transfer fields.
  assign m_awlen   = 8'd0;
  assign m_arlen   = 8'd0;
  assign m_awsize  = size_code(BYTES);
  assign m_arsize  = size_code(BYTES);
  assign m_awburst = BURST_INCR;
  assign m_arburst = BURST_INCR;
  assign m_wstrb   = '1;
  assign m_wlast   = 1'b1;
endmodule

// File: rtl/axi_word_master_chk.sv
module axi_word_master_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_req,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic [DATA_W-1:0] m_wdata,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic [ADDR_W-1:0] m_araddr,
  input logic              m_bvalid,
  input logic              m_bready,
  input logic [1:0]        m_bresp,
  input logic              m_rvalid,
  input logic              m_rready,
  input logic [1:0]        m_rresp,
  input logic [DATA_W-1:0] m_rdata,
  input logic              rsp_done,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err
);
  logic beat;
  assign beat = (m_wvalid && m_wready) || (m_rvalid && m_rready);

  assert_aw_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));
  assert_w_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata)));
  assert_ar_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));
  assert_no_mix_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_arvalid && (m_awvalid || m_wvalid)));
  assert_done_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> rsp_done);
  assert_done_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && cmd_req) |=> rsp_done);
  assert_done_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_req && !beat) |=> !rsp_done);
  assert_rdata_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rvalid && m_rready) |=> (rsp_rdata == $past(m_rdata)));
  assert_rdata_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_rvalid && m_rready) |=> $stable(rsp_rdata));
  assert_berr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_bvalid && m_bready && (m_bresp != 2'b00)) |=> rsp_err);
  assert_rerr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rvalid && m_rready && (m_rresp != 2'b00)) |=> rsp_err);
  assert_ready_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_bready && m_rready));
endmodule

bind axi_word_master axi_word_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_req(cmd_req),
  .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
  .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
  .m_arvalid(m_arvalid), .m_arready(m_arready), .m_araddr(m_araddr),
  .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
  .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rresp(m_rresp), .m_rdata(m_rdata),
  .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
);

// File: tb/tb_axi_word_master.sv
module tb_axi_word_master;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_req, cmd_is_write;
  logic [31:0] cmd_addr, cmd_wdata;
  logic        rsp_done, rsp_err;
  logic [31:0] rsp_rdata;
  logic [31:0] m_awaddr, m_wdata, m_araddr, m_rdata;
  logic [7:0]  m_awlen, m_arlen;
  logic [2:0]  m_awsize, m_arsize;
  logic [1:0]  m_awburst, m_arburst, m_bresp, m_rresp;
  logic [3:0]  m_wstrb;
  logic        m_awvalid, m_awready, m_wlast, m_wvalid, m_wready;
  logic        m_bvalid, m_bready, m_arvalid, m_arready, m_rvalid, m_rready;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  axi_word_master dut (.*);

  // ---- model slave ----
  logic [31:0] mem [0:15];
  int          stall;
  logic [1:0]  bresp_cfg, rresp_cfg;
  int          aw_wait, w_wait, ar_wait;
  int          aw_count, w_count, ar_count;
  logic        aw_seen, w_seen;
  logic [31:0] aw_log, w_log, ar_log, pend_wdata;
  logic [31:0] pend_addr;
  logic        aw_fmt_ok, w_fmt_ok, ar_fmt_ok;

  assign m_awready = m_awvalid && (aw_wait >= stall);
  assign m_wready  = m_wvalid  && (w_wait  >= stall);
  assign m_arready = m_arvalid && (ar_wait >= stall);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_wait <= 0; w_wait <= 0; ar_wait <= 0;
      aw_count <= 0; w_count <= 0; ar_count <= 0;
      aw_seen <= 1'b0; w_seen <= 1'b0;
      m_bvalid <= 1'b0; m_bresp <= 2'b00;
      m_rvalid <= 1'b0; m_rresp <= 2'b00; m_rdata <= '0;
      aw_fmt_ok <= 1'b1; w_fmt_ok <= 1'b1; ar_fmt_ok <= 1'b1;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      aw_wait <= (m_awvalid && !m_awready) ? aw_wait + 1 : 0;
      w_wait  <= (m_wvalid  && !m_wready)  ? w_wait + 1  : 0;
      ar_wait <= (m_arvalid && !m_arready) ? ar_wait + 1 : 0;
      if (m_awvalid && m_awready) begin
        aw_seen <= 1'b1; aw_count <= aw_count + 1;
        aw_log <= m_awaddr; pend_addr <= m_awaddr;
        aw_fmt_ok <= (m_awlen == 8'd0) && (m_awsize == 3'b010) && (m_awburst == 2'b01);
      end
      if (m_wvalid && m_wready) begin
        w_seen <= 1'b1; w_count <= w_count + 1;
        w_log <= m_wdata; pend_wdata <= m_wdata;
        w_fmt_ok <= (m_wstrb == 4'hF) && m_wlast;
      end
      if (m_bvalid && m_bready) begin
        m_bvalid <= 1'b0;
      end else if (aw_seen && w_seen && !m_bvalid) begin
        m_bvalid <= 1'b1; m_bresp <= bresp_cfg;
        mem[pend_addr[5:2]] <= pend_wdata;
        aw_seen <= 1'b0; w_seen <= 1'b0;
      end
      if (m_arvalid && m_arready) begin
        ar_count <= ar_count + 1; ar_log <= m_araddr;
        ar_fmt_ok <= (m_arlen == 8'd0) && (m_arsize == 3'b010) && (m_arburst == 2'b01);
        m_rvalid <= 1'b1; m_rresp <= rresp_cfg; m_rdata <= mem[m_araddr[5:2]];
      end else if (m_rvalid && m_rready) begin
        m_rvalid <= 1'b0;
      end
    end
  end

  // ---- helpers ----
  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic start_req(input logic wr, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    cmd_is_write = wr; cmd_addr = a; cmd_wdata = d; cmd_req = 1'b1;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!rsp_done && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic drop_req();
    @(negedge clk); cmd_req = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_txn(input logic wr, input logic [31:0] a, input logic [31:0] d);
    start_req(wr, a, d); wait_done(); drop_req();
  endtask

  // ---- scenarios ----
  task automatic t_reset();
    chk(!m_awvalid && !m_wvalid && !m_arvalid, "R1 valids low in reset", {29'd0, m_awvalid, m_wvalid, m_arvalid}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk(!m_awvalid && !m_wvalid && !m_arvalid && !m_bready && !m_rready,
        "R1 channel outputs after reset", {27'd0, m_awvalid, m_wvalid, m_arvalid, m_bready, m_rready}, 0);
    chk(!rsp_done && !rsp_err, "R1 done/err after reset", {30'd0, rsp_done, rsp_err}, 0);
  endtask

  task automatic t_round_trip();
    logic [31:0] addrs [4] = '{32'h14, 32'h78, 32'h1C, 32'h08};
    logic [31:0] vals  [4] = '{32'hA5A5_0014, 32'h0000_0078, 32'hDEAD_001E, 32'h1234_000A};
    for (int i = 0; i < 4; i++) do_txn(1'b1, addrs[i], vals[i]);
    chk(aw_fmt_ok && w_fmt_ok, "R5 write beat fields", {30'd0, aw_fmt_ok, w_fmt_ok}, 3);
    for (int i = 0; i < 4; i++) begin
      start_req(1'b0, addrs[i], 32'h0); wait_done();
      chk(rsp_rdata == vals[i], "R2 read returns written word", rsp_rdata, vals[i]);
      drop_req();
    end
    chk(ar_fmt_ok, "R5 read beat fields", {31'd0, ar_fmt_ok}, 1);
  endtask

  task automatic t_held();
    int aw0 = aw_count, w0 = w_count, ar0 = ar_count;
    start_req(1'b1, 32'h30, 32'h5555_AAAA); wait_done();
    repeat (30) @(negedge clk);
    chk(aw_count - aw0 == 1 && w_count - w0 == 1, "R3 one write per held request", aw_count - aw0, 1);
    chk(ar_count == ar0, "R3 no read during write", ar_count - ar0, 0);
    chk(m_bready == 1'b0 && m_rready == 1'b0, "R11 readies low when idle", {30'd0, m_bready, m_rready}, 0);
    chk(rsp_done, "R4 done held while request high", rsp_done, 1);
    @(negedge clk); cmd_req = 1'b0;
    @(negedge clk);
    chk(!rsp_done, "R4 done cleared after drop", rsp_done, 0);
    repeat (3) @(negedge clk);
    ar0 = ar_count; aw0 = aw_count;
    start_req(1'b0, 32'h30, 32'h0); wait_done();
    repeat (20) @(negedge clk);
    chk(ar_count - ar0 == 1 && aw_count == aw0, "R3 one read per held request", ar_count - ar0, 1);
    drop_req();
  endtask

  task automatic t_stall_latch();
    stall = 6;
    start_req(1'b1, 32'h24, 32'hCAFE_F00D);
    @(negedge clk); cmd_addr = 32'h3C; cmd_wdata = 32'hBAD0_BAD0;
    repeat (2) @(negedge clk);
    chk(m_awvalid && m_wvalid && !m_awready, "R6 write valids held under stall", {30'd0, m_awvalid, m_wvalid}, 3);
    chk(m_bready && !m_rready, "R11 only BREADY during write", {30'd0, m_bready, m_rready}, 2);
    wait_done();
    chk(aw_log == 32'h24, "R7 write address latched", aw_log, 32'h24);
    chk(w_log == 32'hCAFE_F00D, "R7 write data latched", w_log, 32'hCAFE_F00D);
    drop_req();
    start_req(1'b0, 32'h24, 32'h0);
    @(negedge clk); cmd_addr = 32'h3C;
    repeat (2) @(negedge clk);
    chk(m_arvalid && m_rready && !m_bready, "R6 read valid held under stall", {30'd0, m_arvalid, m_rready}, 3);
    wait_done();
    chk(ar_log == 32'h24, "R7 read address latched", ar_log, 32'h24);
    chk(rsp_rdata == 32'hCAFE_F00D, "R2 stalled read data", rsp_rdata, 32'hCAFE_F00D);
    drop_req();
    stall = 0;
  endtask

  task automatic t_error();
    bresp_cfg = 2'b10;
    do_txn(1'b1, 32'h04, 32'h1);
    chk(rsp_err, "R8 BRESP error sets flag", rsp_err, 1);
    bresp_cfg = 2'b00;
    do_txn(1'b1, 32'h04, 32'h2);
    chk(!rsp_err, "R8 next start clears flag", rsp_err, 0);
    rresp_cfg = 2'b11;
    start_req(1'b0, 32'h04, 32'h0); wait_done(); @(negedge clk);
    chk(rsp_err, "R8 RRESP error sets flag", rsp_err, 1);
    drop_req();
    rresp_cfg = 2'b00;
    do_txn(1'b0, 32'h04, 32'h0);
    chk(!rsp_err, "R8 okay read clears flag", rsp_err, 0);
  endtask

  task automatic t_busy_edge();
    int ar0 = ar_count, aw0 = aw_count;
    stall = 15;
    start_req(1'b0, 32'h14, 32'h0);
    repeat (3) @(negedge clk); cmd_req = 1'b0;
    repeat (2) @(negedge clk); cmd_req = 1'b1; cmd_is_write = 1'b1;
    wait_done();
    repeat (25) @(negedge clk);
    chk(ar_count - ar0 == 1 && aw_count == aw0, "R9 edge while busy ignored", ar_count - ar0, 1);
    chk(rsp_rdata == 32'hA5A5_0014, "R9 single read data", rsp_rdata, 32'hA5A5_0014);
    drop_req();
    stall = 0;
  endtask

  task automatic t_rdata_hold();
    do_txn(1'b0, 32'h78, 32'h0);
    do_txn(1'b1, 32'h2C, 32'h7777_1111);
    chk(rsp_rdata == 32'h0000_0078, "R10 read word held over write", rsp_rdata, 32'h0000_0078);
    do_txn(1'b0, 32'h2C, 32'h0);
    chk(rsp_rdata == 32'h7777_1111, "R10 next read reloads", rsp_rdata, 32'h7777_1111);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_req = 1'b0; cmd_is_write = 1'b0; cmd_addr = '0; cmd_wdata = '0;
    stall = 0; bresp_cfg = 2'b00; rresp_cfg = 2'b00;
    repeat (3) @(negedge clk);
    t_reset();
    t_round_trip();
    t_held();
    t_stall_latch();
    t_error();
    t_busy_edge();
    t_rdata_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule